// File: doc/BRIEF.md
# Clipped-Sine Multilevel PWM Modulator

This block drives the switch legs of a cascaded H-bridge inverter built from `N_CELLS` identical cells. A phase accumulator steps through one electrical period. Each step adds a frequency tuning word on a divided clock tick. The six most significant phase bits address a 64-point sine, which is rebuilt from a 17-entry quarter-wave table. The resulting reference has a peak `PEAK = N_CELLS * STEP`. It is scaled up by 1157/1024, a factor of about 1.13, and then clamped back to plus or minus `PEAK`. The clamp gives a modulation signal with flattened crests and steeper zero crossings.

The clamped signal is compared against a stack of `2*N_CELLS` in-phase triangular carriers. Each carrier covers one band of height `STEP`. The comparison yields a signed level index between `-N_CELLS` and `+N_CELLS`, and the index is decoded into one positive/zero/negative command per cell. With the defaults (3 cells, step 250, tick divider 125, 125 MHz clock) the output has 7 levels, the peak is 750 and the carrier runs at 2 kHz. A value of 6 cells gives 13 levels. Dead time, gate drivers and the power stage lie outside this block.

Top module: `cspwm_mod`

## Requirements
- R1: A tick occurs on each enabled clock when `TICK_DIV` is 1, otherwise on every `TICK_DIV`-th enabled clock. Each tick adds `ftw_i` to a `PH_W`-bit phase. The reference equals `PEAK*sin(2*pi*i/64)` within one unit, where i is the phase's top six bits.
- R2: `mod_o` equals the reference times 1157/1024, rounded down and then saturated to the range [-PEAK, +PEAK]. Its magnitude never exceeds `PEAK`, and both rails are reached during a period.
- R3: A carrier counter c runs 0..2*STEP-1, advancing one count per tick and wrapping. The triangle value is tri = c when c < STEP, and 2*STEP-1-c otherwise. The carrier period is 2*STEP ticks, which is 2 kHz at the defaults.
- R4: `level_o` is the count of k in 0..N-1 with mod > k*STEP+tri, minus the count of k with mod < -(k+1)*STEP+1+tri.
- R5: `level_o` always stays within [-N_CELLS, +N_CELLS].
- R6: Cell k (1..N) occupies `legs_o[2k-1:2k-2]`. The code 2'b10 (upper bit set) means +1 and is driven when level >= k. The code 2'b01 means -1 and is driven when level <= -k. The code 2'b00 means 0 and is driven otherwise.
- R7: No cell ever shows 2'b11.
- R8: While `mod_o` sits on +PEAK the level is +N_CELLS, and on -PEAK it is -N_CELLS. The leg commands do not change across consecutive cycles spent on the same rail.
- R9: While `en_i` is low, the phase and the carrier hold their values, so all outputs hold.
- R10: While `rst_ni` is low, every output is zero and every cell is in the 0 state.
- R11: The outputs are registered. A tick taken at one clock edge shows on the outputs one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for phase and carrier |
| ftw_i | input | PH_W | Phase increment per tick |
| legs_o | output | 2*N_CELLS | Per-cell leg pair, {pos,neg} |
| level_o | output | LVL_W | Signed output level index |
| mod_o | output | SMP_W | Signed clipped modulation sample |

## Verification
A corrupted phase or table entry distorts `mod_o` one edge after the tick that exposes it. The stepped full-period sweep catches this against a real-valued sine. A stuck or misaligned carrier counter breaks the band comparison within one carrier period. The scoreboard models the triangle from tick counts alone, so it detects that quickly. Errors in the clamp or in the cell decode show on the very next cycle, as a sample beyond the rail, as a level away from ±N at a crest, or as legs that disagree with the level.

// File: rtl/cspwm_pkg.sv
package cspwm_pkg;

  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_NEG = 2'b01,
    LEG_POS = 2'b10
  } leg_e;

  localparam int QSIN_SHIFT = 15;

  // round(32767*sin(k*pi/32)), k = 0..16
  function automatic int qsin(input logic [4:0] k);
    case (k)
      5'd0:    return 0;
      5'd1:    return 3212;
      5'd2:    return 6393;
      5'd3:    return 9512;
      5'd4:    return 12539;
      5'd5:    return 15446;
      5'd6:    return 18204;
      5'd7:    return 20787;
      5'd8:    return 23170;
      5'd9:    return 25329;
      5'd10:   return 27245;
      5'd11:   return 28898;
      5'd12:   return 30273;
      5'd13:   return 31356;
      5'd14:   return 32137;
      5'd15:   return 32609;
      default: return 32767;
    endcase
  endfunction

endpackage

// File: rtl/cspwm_phase.sv
module cspwm_phase #(
  parameter int PH_W     = 16,
  parameter int TICK_DIV = 125
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PH_W-1:0] ftw_i,
  output logic            tick_o,
  output logic [PH_W-1:0] phase_o
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tick_o = en_i;
    end else begin : g_div
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      div_q <= '0;
        else if (en_i)    div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end
      assign tick_o = en_i && (div_q == DIV_LAST);
    end
  endgenerate

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_o) phase_q <= phase_q + ftw_i;
  end

  assign phase_o = phase_q;

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q)); // R9

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (phase_q == $past(phase_q) + $past(ftw_i))); // R1

endmodule

// File: rtl/cspwm_ref.sv
module cspwm_ref #(
  parameter int SMP_W     = 11,
  parameter int PEAK      = 750,
  parameter int BOOST_NUM = 1157,
  parameter int BOOST_SH  = 10
) (
  input  logic [5:0]              idx_i,
  output logic signed [SMP_W-1:0] mod_o
);

  import cspwm_pkg::*;

  logic [4:0] qk;
  int         mag_v, ref_v, boost_v, clip_v;

  always_comb begin
    qk      = idx_i[4] ? (5'd16 - {1'b0, idx_i[3:0]}) : {1'b0, idx_i[3:0]};
    mag_v   = (qsin(qk) * PEAK) >>> QSIN_SHIFT;
    ref_v   = idx_i[5] ? -mag_v : mag_v;
    boost_v = (ref_v * BOOST_NUM) >>> BOOST_SH;
    if (boost_v > PEAK)       clip_v = PEAK;
    else if (boost_v < -PEAK) clip_v = -PEAK;
    else                      clip_v = boost_v;
  end

  assign mod_o = SMP_W'(clip_v);

endmodule

// File: rtl/cspwm_carrier.sv
module cspwm_carrier #(
  parameter int STEP = 250
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  output logic [$clog2(STEP)-1:0]   tri_o
);

  localparam int TRI_W = $clog2(STEP);
  localparam int CNT_W = $clog2(2 * STEP);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * STEP - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(STEP);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tri_o = (cnt_q < CNT_HALF) ? TRI_W'(cnt_q) : TRI_W'(CNT_LAST - cnt_q);

  AST_CAR_SMOOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ((tri_o == $past(tri_o)) || ({1'b0, tri_o} == {1'b0, $past(tri_o)} + 1'b1)
                || ({1'b0, $past(tri_o)} == {1'b0, tri_o} + 1'b1))); // R3

  AST_CAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/cspwm_level.sv
module cspwm_level #(
  parameter int N_CELLS = 3,
  parameter int STEP    = 250,
  parameter int SMP_W   = 11,
  parameter int LVL_W   = 3
) (
  input  logic signed [SMP_W-1:0]    mod_i,
  input  logic [$clog2(STEP)-1:0]    tri_i,
  output logic signed [LVL_W-1:0]    level_o,
  output logic [2*N_CELLS-1:0]       legs_o
);

  import cspwm_pkg::*;

  int m_v, t_v;
  assign m_v = int'(mod_i);
  assign t_v = int'(tri_i);

  logic [N_CELLS-1:0] pos_hit, neg_hit;

  generate
    for (genvar k = 0; k < N_CELLS; k++) begin : g_band
      assign pos_hit[k] = m_v > (k * STEP + t_v);
      assign neg_hit[k] = m_v < (1 - (k + 1) * STEP + t_v);
    end
  endgenerate

  int lvl_v;
  always_comb begin
    lvl_v = 0;
    for (int k = 0; k < N_CELLS; k++) begin
      lvl_v = lvl_v + int'(pos_hit[k]) - int'(neg_hit[k]);
    end
  end

  assign level_o = LVL_W'(lvl_v);

  generate
    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
      leg_e st;
      always_comb begin
        if (lvl_v >= k + 1)       st = LEG_POS;
        else if (lvl_v <= -k - 1) st = LEG_NEG;
        else                      st = LEG_OFF;
      end
      assign legs_o[2*k +: 2] = st;
    end
  endgenerate

endmodule

// File: rtl/cspwm_mod.sv
module cspwm_mod #(
  parameter int N_CELLS  = 3,
  parameter int STEP     = 250,
  parameter int PH_W     = 16,
  parameter int TICK_DIV = 125,
  parameter int PEAK     = N_CELLS * STEP,
  parameter int SMP_W    = $clog2(PEAK + 1) + 1,
  parameter int LVL_W    = $clog2(N_CELLS + 1) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [PH_W-1:0]         ftw_i,
  output logic [2*N_CELLS-1:0]    legs_o,
  output logic signed [LVL_W-1:0] level_o,
  output logic signed [SMP_W-1:0] mod_o
);

  localparam int TRI_W = $clog2(STEP);

  logic                    tick;
  logic [PH_W-1:0]         phase;
  logic [TRI_W-1:0]        tri_v;
  logic signed [SMP_W-1:0] mod_d;
  logic signed [LVL_W-1:0] level_d;
  logic [2*N_CELLS-1:0]    legs_d;

  cspwm_phase #(.PH_W(PH_W), .TICK_DIV(TICK_DIV)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ftw_i(ftw_i),
    .tick_o(tick), .phase_o(phase)
  );

  cspwm_ref #(.SMP_W(SMP_W), .PEAK(PEAK), .BOOST_NUM(1157), .BOOST_SH(10)) u_ref (
    .idx_i(phase[PH_W-1 -: 6]), .mod_o(mod_d)
  );

  cspwm_carrier #(.STEP(STEP)) u_car (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .tri_o(tri_v)
  );

  cspwm_level #(.N_CELLS(N_CELLS), .STEP(STEP), .SMP_W(SMP_W), .LVL_W(LVL_W)) u_lvl (
    .mod_i(mod_d), .tri_i(tri_v), .level_o(level_d), .legs_o(legs_d)
  );

  logic signed [SMP_W-1:0] mod_q;
  logic signed [LVL_W-1:0] level_q;
  logic [2*N_CELLS-1:0]    legs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q   <= '0;
      level_q <= '0;
      legs_q  <= '0;
    end else begin
      mod_q   <= mod_d;
      level_q <= level_d;
      legs_q  <= legs_d;
    end
  end

  assign mod_o   = mod_q;
  assign level_o = level_q;
  assign legs_o  = legs_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q <= PEAK) && (mod_q >= -PEAK)); // R2

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q <= N_CELLS) && (level_q >= -N_CELLS)); // R5

  AST_CREST_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q == PEAK) |-> (level_q == N_CELLS)); // R8

  AST_CREST_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q == -PEAK) |-> (level_q == -N_CELLS)); // R8

  AST_CREST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mod_q == PEAK) && $past(mod_q == PEAK)) |-> $stable(legs_q)); // R8

  generate
    for (genvar k = 0; k < N_CELLS; k++) begin : g_chk
      AST_LEG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legs_q[2*k +: 2] != 2'b11); // R7
      AST_CELL_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_q > k) |-> (legs_q[2*k +: 2] == 2'b10)); // R6
    end
  endgenerate

endmodule

// File: tb/sim_cspwm_mod.sv
module sim_cspwm_mod;

  localparam int N    = 3;
  localparam int H    = 250;
  localparam int P    = N * H;
  localparam int PH_W = 16;
  localparam int SMP_W = $clog2(P + 1) + 1;
  localparam int LVL_W = $clog2(N + 1) + 1;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    en = 1'b0;
  logic [PH_W-1:0]         ftw = '0;
  logic [2*N-1:0]          legs_o;
  logic signed [LVL_W-1:0] level_o;
  logic signed [SMP_W-1:0] mod_o;

  always #4 clk = ~clk;

  cspwm_mod #(.N_CELLS(N), .STEP(H), .PH_W(PH_W), .TICK_DIV(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ftw_i(ftw),
    .legs_o(legs_o), .level_o(level_o), .mod_o(mod_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tri_of(input int t);
    int c;
    c = t % (2 * H);
    return (c < H) ? c : (2 * H - 1 - c);
  endfunction

  function automatic int exp_level(input int m, input int t);
    int lv;
    lv = 0;
    for (int k = 0; k < N; k++) begin
      if (m > k * H + t) lv++;
      if (m < 1 - (k + 1) * H + t) lv--;
    end
    return lv;
  endfunction

  function automatic logic [2*N-1:0] exp_legs(input int lv);
    logic [2*N-1:0] r;
    r = '0;
    for (int k = 1; k <= N; k++) begin
      if (lv >= k)       r[2*k-1 -: 2] = 2'b10;
      else if (lv <= -k) r[2*k-1 -: 2] = 2'b01;
    end
    return r;
  endfunction

  // driver side: expected carrier for the sample registered at this edge
  int ticks = 0;
  int car_q[$];
  always @(posedge clk) begin
    if (rst_n) begin
      car_q.push_back(tri_of(ticks));
      if (en) ticks++;
    end
  end

  // monitor side
  int             prev_mod = 0;
  logic [2*N-1:0] prev_legs = '0;
  int             crest_p = 0, crest_n = 0;
  always @(negedge clk) begin
    if (rst_n && !done && car_q.size() > 0) begin
      int t, m, lv;
      t  = car_q.pop_front();
      m  = int'(mod_o);
      lv = exp_level(m, t);
      check(int'(level_o) == lv, "R4 level", int'(level_o), lv);
      check(int'(level_o) <= N && int'(level_o) >= -N, "R5 range", int'(level_o), N);
      check(legs_o == exp_legs(lv), "R6 legs", int'(legs_o), int'(exp_legs(lv)));
      for (int k = 0; k < N; k++)
        check(legs_o[2*k +: 2] != 2'b11, "R7 excl", int'(legs_o[2*k +: 2]), 0);
      check(m <= P && m >= -P, "R2 bound", m, P);
      if (m == P) begin
        crest_p++;
        check(int'(level_o) == N, "R8 crest+", int'(level_o), N);
        if (prev_mod == P) check(legs_o == prev_legs, "R8 quiet", int'(legs_o), int'(prev_legs));
      end
      if (m == -P) begin
        crest_n++;
        check(int'(level_o) == -N, "R8 crest-", int'(level_o), -N);
        if (prev_mod == -P) check(legs_o == prev_legs, "R8 quiet", int'(legs_o), int'(prev_legs));
      end
      prev_mod  = m;
      prev_legs = legs_o;
    end
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int last;
    real ev;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(legs_o == '0, "R10 legs", int'(legs_o), 0);
    check(int'(level_o) == 0, "R10 level", int'(level_o), 0);
    check(int'(mod_o) == 0, "R10 mod", int'(mod_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R2/R11: one tick at a time through a full period
    ftw  = 16'd1024;
    last = int'(mod_o);
    for (int n = 1; n <= 64; n++) begin
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      check(int'(mod_o) == last, "R11 latency", int'(mod_o), last);
      @(negedge clk);
      ev = real'(P) * $sin(2.0 * 3.14159265358979 * real'(n % 64) / 64.0) * 1157.0 / 1024.0;
      if (ev > real'(P))  ev = real'(P);
      if (ev < -real'(P)) ev = -real'(P);
      check((real'(mod_o) - ev) <= 3.0 && (ev - real'(mod_o)) <= 3.0,
            "R1/R2 sample", int'(mod_o), $rtoi(ev));
      last = int'(mod_o);
    end

    // R9: enable low holds everything
    begin
      int hm, hl;
      logic [2*N-1:0] hg;
      ftw = 16'd4000;
      hm = int'(mod_o); hl = int'(level_o); hg = legs_o;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        check(int'(mod_o) == hm, "R9 mod hold", int'(mod_o), hm);
        check(int'(level_o) == hl, "R9 level hold", int'(level_o), hl);
        check(legs_o == hg, "R9 legs hold", int'(legs_o), int'(hg));
      end
    end

    // R3/R4/R8: free run across several carrier periods and two sine periods
    ftw = 16'd7;
    en  = 1'b1;
    repeat (20000) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    check(crest_p > 0, "R2 rail+ reached", crest_p, 1);
    check(crest_n > 0, "R2 rail- reached", crest_n, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule